// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Peripheral

This peripheral sits on an APB-style register bus. It holds several independent countdown timers, and each timer has its own register window and its own interrupt line. Software writes a start count and picks a run style for each channel. In the repeating style the counter reloads itself every time it expires. In the one-shot style it runs down once and then stays at zero. All logic runs on the bus clock.

Each channel has several controls: a run-style bit, a start-count register, a run/stop bit and a write-triggered reload. Software can read the live count, read the pending event flag, mask the channel's interrupt, and clear the pending flag. Once a clear is accepted, a short busy window opens. During that window further clear requests are dropped, and the busy state can be read back so that software knows when to try again.

Top module: `apb_multi_timer`

## Requirements
- R1: Channel n occupies the byte window starting at n × 0x40, selected by address bits [7:6]. Inside a window the fields sit at these offsets: pending status 0x00, run style 0x04, start count 0x08, run/stop 0x10, reload trigger 0x14, live count 0x18, clear 0x20, mask 0x24. The reload trigger and every other offset read back as zero.
- R2: Bit 0 at offset 0x04 selects the run style, where 0 means repeating and 1 means one-shot. It reads back as written.
- R3: Offset 0x08 holds a 32-bit start count that reads back as written, including 0xFFFFFFFF. Writing it alone does not change the live count.
- R4: Any write to offset 0x14, whatever the data, copies the start count into the live count on that write's clock edge. This happens whether or not the channel is running, and it takes priority over counting.
- R5: Bit 0 at offset 0x10 runs the channel when set. While running, a live count above 1 drops by one per clock. While stopped, the count holds. The live count reads at offset 0x18.
- R6: When a running channel's count is 1 at a clock edge, the channel expires and its pending flag sets. A repeating channel reloads the start count. A one-shot channel goes to 0 and then holds 0.
- R7: The pending flag reads as bit 0 of offset 0x00 and as bit 0 of offset 0x20.
- R8: A write to offset 0x20 with bit 0 = 1 clears the pending flag when no clear is busy. A write with bit 0 = 0 has no effect. If an expiry happens on the same edge as a clear, the expiry wins.
- R9: An accepted clear sets bit 1 of offset 0x20 for exactly two cycles. Clear writes made while that bit is 1 are ignored.
- R10: Bit 0 at offset 0x24 masks the channel when set. The channel's irq bit equals pending AND NOT mask.
- R11: Accesses to one channel's window never change another channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock; all state is clocked on its rising edge |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase qualifier |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address; [7:6] channel, [5:0] offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed field (combinational) |
| irq | output | 4 | Per-channel interrupt, pending and unmasked |

## Verification
The bench builds the block with its default values: four channels, a 32-bit counter and a two-cycle clear hold. Random start counts are kept below twelve, so expiries, repeating reloads and one-shot stops happen many times within a short run. Clears are issued back to back, so repeating expiries land inside busy windows and show whether clears during a busy window are dropped. Directed steps cover the full-scale count of 0xFFFFFFFF and unmapped offsets, and they mix accesses across channels to check that channels stay independent.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the multi-channel countdown timer.
// Assumes word-aligned byte offsets inside a 64-byte channel window.
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int WIN_LOG2 = 6;

    localparam logic [WIN_LOG2-1:0] OFF_STAT   = 6'h00;
    localparam logic [WIN_LOG2-1:0] OFF_MODE   = 6'h04;
    localparam logic [WIN_LOG2-1:0] OFF_LOAD   = 6'h08;
    localparam logic [WIN_LOG2-1:0] OFF_EN     = 6'h10;
    localparam logic [WIN_LOG2-1:0] OFF_RELOAD = 6'h14;
    localparam logic [WIN_LOG2-1:0] OFF_VALUE  = 6'h18;
    localparam logic [WIN_LOG2-1:0] OFF_CLR    = 6'h20;
    localparam logic [WIN_LOG2-1:0] OFF_MASK   = 6'h24;

    typedef enum logic {
        RUN_REPEAT  = 1'b0,
        RUN_ONESHOT = 1'b1
    } run_style_e;

    typedef struct packed {
        logic wr_mode;
        logic wr_load;
        logic wr_en;
        logic wr_reload;
        logic wr_clr;
        logic wr_mask;
    } tmr_wr_s;
endpackage

// File: rtl/tmr_decode.sv
// Address decode: splits the byte address into channel index and window
// offset and turns a completed bus write into one strobe per channel field.
// Assumes a zero-wait bus: a write completes when psel & penable & pwrite.
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = SEL_W + WIN_LOG2
) (
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    output logic [SEL_W-1:0]            ch_idx,
    output logic                        ch_valid,
    output logic [WIN_LOG2-1:0]         offset,
    output tmr_wr_s [NUM_CH-1:0]        wr_vec
);
    logic wr_act;

    assign wr_act   = psel && penable && pwrite;
    assign ch_idx   = paddr[ADDR_W-1:WIN_LOG2];
    assign offset   = paddr[WIN_LOG2-1:0];
    assign ch_valid = (int'(ch_idx) < NUM_CH);

    // Produce the field write strobes for the addressed channel only.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr_vec[c] = '0;
            if (wr_act && (ch_idx == SEL_W'(c))) begin
                case (offset)
                    OFF_MODE:   wr_vec[c].wr_mode   = 1'b1;
                    OFF_LOAD:   wr_vec[c].wr_load   = 1'b1;
                    OFF_EN:     wr_vec[c].wr_en     = 1'b1;
                    OFF_RELOAD: wr_vec[c].wr_reload = 1'b1;
                    OFF_CLR:    wr_vec[c].wr_clr    = 1'b1;
                    OFF_MASK:   wr_vec[c].wr_mask   = 1'b1;
                    default:    wr_vec[c]           = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_clr_gate.sv
// Clear handshake: accepts a clear request only when idle, then keeps the
// busy indication high for HOLD cycles, dropping requests meanwhile.
// Assumes HOLD >= 1.
module tmr_clr_gate #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    output logic clr_accept,
    output logic busy
);
    localparam int BW = $clog2(HOLD + 1);

    logic [BW-1:0] hold_cnt;

    assign busy       = (hold_cnt != '0);
    assign clr_accept = clr_req && !busy;

    // Load the hold window on an accepted clear and run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (clr_accept)
            hold_cnt <= BW'(HOLD);
        else if (busy)
            hold_cnt <= hold_cnt - 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// One countdown channel: control fields, counter with repeat/one-shot
// behaviour, pending flag, clear handshake, mask and field read mux.
// Assumes CNT_W <= DATA_W and one write strobe at most per cycle.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int CLR_HOLD = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tmr_wr_s             wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [WIN_LOG2-1:0] rd_off,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq,
    output logic [CNT_W-1:0]    obs_cnt,
    output logic                obs_pend,
    output logic                obs_busy,
    output logic                obs_mask,
    output logic                obs_en,
    output logic                obs_style
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    run_style_e       style;
    logic [CNT_W-1:0] start_cnt;
    logic [CNT_W-1:0] live_cnt;
    logic             run_en;
    logic             mask;
    logic             pend;
    logic             clr_accept;
    logic             busy;
    logic             expire;

    assign expire = run_en && !wr.wr_reload && (live_cnt == CNT_ONE);

    tmr_clr_gate #(.HOLD(CLR_HOLD)) u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_req    (wr.wr_clr && wdata[0]),
        .clr_accept (clr_accept),
        .busy       (busy)
    );

    // Capture software-written control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style     <= RUN_REPEAT;
            start_cnt <= '0;
            run_en    <= 1'b0;
            mask      <= 1'b0;
        end else begin
            if (wr.wr_mode) style     <= run_style_e'(wdata[0]);
            if (wr.wr_load) start_cnt <= wdata[CNT_W-1:0];
            if (wr.wr_en)   run_en    <= wdata[0];
            if (wr.wr_mask) mask      <= wdata[0];
        end
    end

    // Advance the live count: reload trigger first, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_cnt <= '0;
        else if (wr.wr_reload)
            live_cnt <= start_cnt;
        else if (expire)
            live_cnt <= (style == RUN_ONESHOT) ? '0 : start_cnt;
        else if (run_en && (live_cnt != '0))
            live_cnt <= live_cnt - 1'b1;
    end

    // Pending flag: an expiry sets it and wins over a same-edge clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (expire)
            pend <= 1'b1;
        else if (clr_accept)
            pend <= 1'b0;
    end

    assign irq = pend && !mask;

    // Return the field selected by the window offset.
    always_comb begin
        rd_data = '0;
        case (rd_off)
            OFF_STAT:  rd_data[0]         = pend;
            OFF_MODE:  rd_data[0]         = style;
            OFF_LOAD:  rd_data[CNT_W-1:0] = start_cnt;
            OFF_EN:    rd_data[0]         = run_en;
            OFF_VALUE: rd_data[CNT_W-1:0] = live_cnt;
            OFF_CLR:   rd_data[1:0]       = {busy, pend};
            OFF_MASK:  rd_data[0]         = mask;
            default:   rd_data            = '0;
        endcase
    end

    assign obs_cnt   = live_cnt;
    assign obs_pend  = pend;
    assign obs_busy  = busy;
    assign obs_mask  = mask;
    assign obs_en    = run_en;
    assign obs_style = style;
endmodule

// File: rtl/apb_multi_timer.sv
// Top level: bus decode, NUM_CH countdown channels and the read select.
// Assumes zero-wait transfers; read data is valid during the access phase.
module apb_multi_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CNT_W    = 32,
    parameter int CLR_HOLD = 2,
    localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = SEL_W + WIN_LOG2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NUM_CH-1:0] irq
);
    logic [SEL_W-1:0]               ch_idx;
    logic                           ch_valid;
    logic [WIN_LOG2-1:0]            offset;
    tmr_wr_s [NUM_CH-1:0]           wr_vec;
    logic [NUM_CH-1:0][DATA_W-1:0]  rd_bus;
    logic [NUM_CH-1:0][CNT_W-1:0]   obs_cnt;
    logic [NUM_CH-1:0]              obs_pend;
    logic [NUM_CH-1:0]              obs_busy;
    logic [NUM_CH-1:0]              obs_mask;
    logic [NUM_CH-1:0]              obs_en;
    logic [NUM_CH-1:0]              obs_style;

    tmr_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dec (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .ch_idx   (ch_idx),
        .ch_valid (ch_valid),
        .offset   (offset),
        .wr_vec   (wr_vec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W), .CLR_HOLD(CLR_HOLD)) u_chan (
            .clk       (pclk),
            .rst_n     (presetn),
            .wr        (wr_vec[c]),
            .wdata     (pwdata),
            .rd_off    (offset),
            .rd_data   (rd_bus[c]),
            .irq       (irq[c]),
            .obs_cnt   (obs_cnt[c]),
            .obs_pend  (obs_pend[c]),
            .obs_busy  (obs_busy[c]),
            .obs_mask  (obs_mask[c]),
            .obs_en    (obs_en[c]),
            .obs_style (obs_style[c])
        );
    end

    // Select the addressed channel's read data; absent channels read zero.
    always_comb begin
        prdata = '0;
        if (ch_valid)
            prdata = rd_bus[ch_idx];
    end
endmodule

// File: rtl/tmr_checker.sv
// Property checker for the countdown timer, bound onto the top level.
// Recomputes bus write qualifiers from the ports on its own.
module tmr_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           psel,
    input logic                           penable,
    input logic                           pwrite,
    input logic [ADDR_W-1:0]              paddr,
    input logic                           clr_bit,
    input logic [NUM_CH-1:0]              irq,
    input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_obs,
    input logic [NUM_CH-1:0]              pend_obs,
    input logic [NUM_CH-1:0]              busy_obs,
    input logic [NUM_CH-1:0]              mask_obs,
    input logic [NUM_CH-1:0]              en_obs,
    input logic [NUM_CH-1:0]              style_obs
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic here, reload_w, clr_w;
        assign here     = psel && penable && pwrite && (paddr[ADDR_W-1:6] == SEL_W'(c));
        assign reload_w = here && (paddr[5:0] == 6'h14);
        assign clr_w    = here && (paddr[5:0] == 6'h20) && clr_bit;

        AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            mask_obs[c] |-> !irq[c]); // R10
        AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> pend_obs[c]); // R10
        AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (en_obs[c] && !reload_w && cnt_obs[c] > ONE) |=> cnt_obs[c] == $past(cnt_obs[c]) - ONE); // R5
        AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_obs[c] && !reload_w) |=> $stable(cnt_obs[c])); // R5
        AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (!rst_n)
            (en_obs[c] && style_obs[c] && cnt_obs[c] == '0 && !reload_w) |=> cnt_obs[c] == '0); // R6
        AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (en_obs[c] && cnt_obs[c] == ONE && !reload_w) |=> pend_obs[c]); // R6
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w && !busy_obs[c] && !(en_obs[c] && cnt_obs[c] == ONE)) |=> !pend_obs[c]); // R8
        AST_BUSY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_obs[c]) |=> busy_obs[c]); // R9
        AST_BUSY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_obs[c] && $past(busy_obs[c])) |=> !busy_obs[c]); // R9
        AST_BUSY_DROPS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_obs[c] && clr_w && pend_obs[c]) |=> pend_obs[c]); // R9
    end
endmodule

bind apb_multi_timer tmr_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (pclk),
    .rst_n     (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .clr_bit   (pwdata[0]),
    .irq       (irq),
    .cnt_obs   (obs_cnt),
    .pend_obs  (obs_pend),
    .busy_obs  (obs_busy),
    .mask_obs  (obs_mask),
    .en_obs    (obs_en),
    .style_obs (obs_style)
);

// File: tb/apb_multi_timer_test.sv
module apb_multi_timer_test;
    logic        clk = 1'b0;
    logic        rstn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference state derived from the requirements
    logic [31:0] m_cnt [4];
    logic [31:0] m_load[4];
    logic        m_mode[4], m_en[4], m_mask[4], m_pend[4];
    int          m_busy[4];

    apb_multi_timer uut (
        .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        logic hit, rld, clr_ok, expire;
        logic [5:0] off;
        for (int c = 0; c < 4; c++) begin
            if (!rstn) begin
                m_cnt[c] = 0; m_load[c] = 0; m_mode[c] = 0; m_en[c] = 0;
                m_mask[c] = 0; m_pend[c] = 0; m_busy[c] = 0;
            end else begin
                hit    = psel && penable && pwrite && (paddr[7:6] == 2'(c));
                off    = paddr[5:0];
                rld    = hit && off == 6'h14;
                clr_ok = hit && off == 6'h20 && pwdata[0] && m_busy[c] == 0;
                expire = m_en[c] && !rld && m_cnt[c] == 1;
                if (rld) m_cnt[c] = m_load[c];
                else if (expire) m_cnt[c] = m_mode[c] ? 32'd0 : m_load[c];
                else if (m_en[c] && m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
                if (expire) m_pend[c] = 1'b1;
                else if (clr_ok) m_pend[c] = 1'b0;
                if (clr_ok) m_busy[c] = 2;
                else if (m_busy[c] > 0) m_busy[c] = m_busy[c] - 1;
                if (hit && off == 6'h04) m_mode[c] = pwdata[0];
                if (hit && off == 6'h08) m_load[c] = pwdata;
                if (hit && off == 6'h10) m_en[c]   = pwdata[0];
                if (hit && off == 6'h24) m_mask[c] = pwdata[0];
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int c = int'(a[7:6]);
        case (a[5:0])
            6'h00: return {31'd0, m_pend[c]};
            6'h04: return {31'd0, m_mode[c]};
            6'h08: return m_load[c];
            6'h10: return {31'd0, m_en[c]};
            6'h18: return m_cnt[c];
            6'h20: return {30'd0, m_busy[c] != 0, m_pend[c]};
            6'h24: return {31'd0, m_mask[c]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] v;
        for (int c = 0; c < 4; c++) v[c] = m_pend[c] && !m_mask[c];
        return v;
    endfunction

    function automatic string req_of(input logic [5:0] off);
        case (off)
            6'h00: return "R7";
            6'h04: return "R2";
            6'h08: return "R3";
            6'h10: return "R5";
            6'h18: return "R5";
            6'h20: return "R9";
            6'h24: return "R10";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        check(req, prdata, exp_read(a));
        check("R10", {28'd0, irq}, {28'd0, exp_irq()});
        @(posedge clk);
        #1 psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [5:0] offs[12] = '{6'h00, 6'h04, 6'h08, 6'h10, 6'h14, 6'h18,
                                 6'h20, 6'h24, 6'h0C, 6'h1C, 6'h3C, 6'h02};
        int unsigned seed_r;
        seed_r = $urandom(32'd20230901);
        idle(3);
        rstn = 1'b1;

        // reset state
        bus_read(8'h18, "R1");
        bus_read(8'hC0, "R7");
        bus_read(8'h3C, "R1");

        // full-scale load, reload with data 0 and 1 (R3, R4)
        bus_write(8'h48, 32'hFFFF_FFFF);
        bus_read(8'h58, "R3");
        bus_read(8'h48, "R3");
        bus_write(8'h54, 32'd0);
        bus_read(8'h58, "R4");
        bus_write(8'h48, 32'd7);
        bus_write(8'h54, 32'd1);
        bus_read(8'h58, "R4");
        bus_write(8'h48, 32'hFFFF_FFFF);
        bus_write(8'h54, 32'd5);
        bus_write(8'h50, 32'd1);
        bus_read(8'h58, "R5");
        bus_read(8'h58, "R5");
        bus_write(8'h50, 32'd0);
        bus_read(8'h58, "R5");
        idle(3);
        bus_read(8'h58, "R5");

        // one-shot expiry and hold on channel 2 (R6)
        bus_write(8'h84, 32'd1);
        bus_write(8'h88, 32'd3);
        bus_write(8'h94, 32'd0);
        bus_write(8'h90, 32'd1);
        idle(8);
        bus_read(8'h98, "R6");
        bus_read(8'h80, "R7");
        bus_read(8'h84, "R2");

        // repeating channel 0
        bus_write(8'h08, 32'd5);
        bus_write(8'h14, 32'd0);
        bus_write(8'h10, 32'd1);
        for (int i = 0; i < 6; i++) bus_read(8'h18, "R6");

        // clear handling on channel 2 (R8, R9)
        bus_write(8'hA0, 32'd0);
        bus_read(8'h80, "R8");
        bus_write(8'hA0, 32'd1);
        bus_read(8'hA0, "R9");
        bus_read(8'h80, "R8");

        // mask on channel 2 after another expiry (R10)
        bus_write(8'h94, 32'd0);
        idle(6);
        bus_write(8'hA4, 32'd1);
        bus_read(8'h80, "R10");
        bus_write(8'hA4, 32'd0);
        bus_read(8'hA4, "R10");

        // back-to-back clears against a fast repeating channel 3 (R9)
        bus_write(8'hC8, 32'd3);
        bus_write(8'hD4, 32'd0);
        bus_write(8'hD0, 32'd1);
        for (int i = 0; i < 10; i++) begin
            bus_write(8'hE0, 32'd1);
            bus_write(8'hE0, 32'd1);
            bus_read(8'hE0, "R9");
        end

        // independence across windows (R11)
        for (int c = 0; c < 4; c++) bus_read({2'(c), 6'h18}, "R11");
        for (int c = 0; c < 4; c++) bus_read({2'(c), 6'h08}, "R11");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] ch = 2'($urandom % 4);
            int k = int'($urandom % 10);
            case (k)
                0: bus_write({ch, 6'h04}, $urandom % 2);
                1: bus_write({ch, 6'h08}, ($urandom % 16 == 0) ? 32'hFFFF_FFFF : $urandom % 12);
                2: bus_write({ch, 6'h10}, ($urandom % 4 != 0) ? 32'd1 : 32'd0);
                3: bus_write({ch, 6'h14}, $urandom);
                4: bus_write({ch, 6'h20}, ($urandom % 4 != 0) ? 32'd1 : 32'd2);
                5: bus_write({ch, 6'h24}, ($urandom % 3 == 0) ? 32'd1 : 32'd0);
                9: idle(1 + int'($urandom % 3));
                default: begin
                    logic [5:0] o = offs[$urandom % 12];
                    bus_read({ch, o}, req_of(o));
                end
            endcase
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule